// File: doc/BRIEF.md
# Multi-Channel DMA Control Register and Interrupt Block

This block is the software-visible control face of a multi-channel DMA engine. It sits on a simple 32-bit read/write bus and holds the per-channel setup registers that the transfer engines consume. Channels come in pairs. Within each pair, the even channel moves data from a device into memory (receive) and the odd channel moves data from memory to a device (transmit). Each pair has its own address window, and the receive and transmit halves of that window have different register layouts.

The block turns register writes into control strobes for the data movers. A write to a transmit descriptor-low register launches that transmit channel. Toggling the receive run bit starts or stops a receive channel. Every channel presents its 64-bit descriptor pointer on a flat output bus.

When a transfer engine finishes, it pulses its done line. That pulse latches a per-channel status bit. The status bits are masked by a per-channel enable set, and the masked result drives one level-sensitive interrupt line. Software clears status bits by writing ones to them. A global control register selects 32-bit addressing for the engines.

Top module: `mdma_csr`

## Requirements
- R1: Pair n owns the byte window starting at n*0x40. Receive registers sit at window offsets 0x00 (descriptor high), 0x04 (descriptor low), 0x0C (length), 0x10 (buffer length) and 0x30 (bytes per row); each holds and reads back a full 32-bit value. The receive run register at 0x14 keeps only bit 0, and its other bits read as zero.
- R2: Transmit registers start at window offset 0x18: descriptor high at +0x00, descriptor low at +0x04, buffer length at +0x0C and length at +0x14. Each holds and reads back a full 32-bit value.
- R3: Channel c drives bits [64c+63:64c] of `ch_desc_addr`. The value is {descriptor high, descriptor low}, where channel 2n uses the receive registers of pair n and channel 2n+1 uses the transmit registers of pair n.
- R4: A write to a transmit descriptor-low register raises `ch_start[2n+1]` for exactly the one clock after the write edge. No more than one start bit is ever high at once, and a start bit is only high after a write.
- R5: Writing 1 to receive run bit 0 while it is clear sets `rx_run[n]` and pulses `ch_start[2n]` for one clock. Writing 0 while it is set clears `rx_run[n]` and pulses `rx_stop[n]` for one clock. Writing the value the bit already holds produces no pulse.
- R6: The address-control register at 0x34 keeps bit 0, which drives `addr32_mode`. Its other bits read as zero. The same offset in any window other than pair 0 is unmapped.
- R7: A pulse on `done[i]` sets interrupt status bit i, readable at 0x080000, on the following clock edge. If a clear of that bit arrives in the same cycle, the set wins.
- R8: Writing to the status register clears each bit written as 1 and leaves each bit written as 0 unchanged. Writing 0xFFFFFFFF clears every bit.
- R9: The enable register at 0x080008 holds one bit per channel in bits [NCH-1:0]. Reading the pending register at 0x080004 returns status AND enable. Writes to the pending register have no effect.
- R10: `irq` is high whenever any status bit is both set and enabled. It is low from the clock after the enable register is written with zero.
- R11: Any unmapped address reads as zero and ignores writes. Unmapped addresses include window offsets 0x08 and 0x20, offset 0x34 outside pair 0, windows at or beyond NUM_PAIRS, and global addresses other than the three interrupt registers.
- R12: After reset, all registers are zero, all outputs are low and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write enable, sampled on the clock edge |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| done | input | NCH | Per-channel transfer-complete pulses |
| ch_start | output | NCH | One-cycle per-channel start pulses |
| rx_run | output | NUM_PAIRS | Receive run state per pair |
| rx_stop | output | NUM_PAIRS | One-cycle receive stop requests per pair |
| ch_desc_addr | output | NCH*64 | Per-channel 64-bit descriptor pointers |
| addr32_mode | output | 1 | 32-bit addressing select |
| irq | output | 1 | Level interrupt request |

## Verification
A wrong decode entry shows up at once on `bus_rdata`: a register reads back at an address where it should not, or an unmapped address returns non-zero in the same cycle. Errors in the status update show up one clock after a done pulse or a clear write, both in the status and pending reads and on `irq`. A wrong run or start register shows up one clock after the triggering write, as a missing, doubled or stuck strobe on `ch_start` or `rx_stop`. A wrong pointer shows up as soon as the descriptor bus settles after the write.

// File: rtl/mdma_pkg.sv
package mdma_pkg;

  localparam int DATA_W    = 32;
  localparam int WIN_SHIFT = 6;

  // window-relative offsets
  localparam logic [5:0] RX_DHI_OFS  = 6'h00;
  localparam logic [5:0] RX_DLO_OFS  = 6'h04;
  localparam logic [5:0] RX_LEN_OFS  = 6'h0C;
  localparam logic [5:0] RX_BLEN_OFS = 6'h10;
  localparam logic [5:0] RX_RUN_OFS  = 6'h14;
  localparam logic [5:0] RX_BPR_OFS  = 6'h30;
  localparam logic [5:0] TX_BASE     = 6'h18;
  localparam logic [5:0] TX_DHI_OFS  = TX_BASE + 6'h00;
  localparam logic [5:0] TX_DLO_OFS  = TX_BASE + 6'h04;
  localparam logic [5:0] TX_BLEN_OFS = TX_BASE + 6'h0C;
  localparam logic [5:0] TX_LEN_OFS  = TX_BASE + 6'h14;
  localparam logic [5:0] ACTL_OFS    = 6'h34;

  localparam logic [31:0] IST_ADDR = 32'h0008_0000;
  localparam logic [31:0] IPD_ADDR = 32'h0008_0004;
  localparam logic [31:0] IEN_ADDR = 32'h0008_0008;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_RX_DHI, SEL_RX_DLO, SEL_RX_LEN, SEL_RX_BLEN, SEL_RX_RUN,
    SEL_RX_BPR, SEL_TX_DHI, SEL_TX_DLO, SEL_TX_BLEN, SEL_TX_LEN,
    SEL_ACTL, SEL_ISTAT, SEL_IPEND, SEL_IEN
  } reg_sel_e;

  // next status: write-one clear, then done pulses set (set wins)
  function automatic logic [31:0] stat_next(input logic [31:0] cur,
                                            input logic [31:0] clr,
                                            input logic [31:0] set);
    return (cur & ~clr) | set;
  endfunction

  function automatic logic [31:0] pend_of(input logic [31:0] st,
                                          input logic [31:0] en);
    return st & en;
  endfunction

endpackage

// File: rtl/mdma_decode.sv
module mdma_decode
  import mdma_pkg::*;
#(
  parameter int ADDR_W    = 20,
  parameter int NUM_PAIRS = 2,
  parameter int PAIR_W    = 1
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_e          sel,
  output logic [PAIR_W-1:0] pair
);
  localparam int WIN_W = ADDR_W - WIN_SHIFT;

  logic [WIN_W-1:0]     win;
  logic [WIN_SHIFT-1:0] ofs;
  logic                 in_win;

  always_comb begin
    win    = addr[ADDR_W-1:WIN_SHIFT];
    ofs    = addr[WIN_SHIFT-1:0];
    in_win = (win < WIN_W'(NUM_PAIRS));
    pair   = win[PAIR_W-1:0];
    sel    = SEL_NONE;
    if (addr == ADDR_W'(IST_ADDR))      sel = SEL_ISTAT;
    else if (addr == ADDR_W'(IPD_ADDR)) sel = SEL_IPEND;
    else if (addr == ADDR_W'(IEN_ADDR)) sel = SEL_IEN;
    else if (in_win) begin
      case (ofs)
        RX_DHI_OFS:  sel = SEL_RX_DHI;
        RX_DLO_OFS:  sel = SEL_RX_DLO;
        RX_LEN_OFS:  sel = SEL_RX_LEN;
        RX_BLEN_OFS: sel = SEL_RX_BLEN;
        RX_RUN_OFS:  sel = SEL_RX_RUN;
        RX_BPR_OFS:  sel = SEL_RX_BPR;
        TX_DHI_OFS:  sel = SEL_TX_DHI;
        TX_DLO_OFS:  sel = SEL_TX_DLO;
        TX_BLEN_OFS: sel = SEL_TX_BLEN;
        TX_LEN_OFS:  sel = SEL_TX_LEN;
        ACTL_OFS:    sel = (win == '0) ? SEL_ACTL : SEL_NONE;
        default:     sel = SEL_NONE;
      endcase
    end
  end
endmodule

// File: rtl/mdma_pair.sv
module mdma_pair
  import mdma_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        hit,
  input  logic        we,
  input  reg_sel_e    sel,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic        rx_run,
  output logic        rx_start,
  output logic        rx_stop,
  output logic        tx_start,
  output logic [63:0] rx_desc,
  output logic [63:0] tx_desc
);
  logic [31:0] rx_dhi, rx_dlo, rx_len, rx_blen, rx_bpr;
  logic [31:0] tx_dhi, tx_dlo, tx_blen, tx_len;
  logic        wr;

  assign wr = hit & we;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_dhi <= '0; rx_dlo <= '0; rx_len <= '0; rx_blen <= '0; rx_bpr <= '0;
      tx_dhi <= '0; tx_dlo <= '0; tx_blen <= '0; tx_len <= '0;
      rx_run <= 1'b0; rx_start <= 1'b0; rx_stop <= 1'b0; tx_start <= 1'b0;
    end else begin
      rx_start <= 1'b0;
      rx_stop  <= 1'b0;
      tx_start <= 1'b0;
      if (wr) begin
        case (sel)
          SEL_RX_DHI:  rx_dhi  <= wdata;
          SEL_RX_DLO:  rx_dlo  <= wdata;
          SEL_RX_LEN:  rx_len  <= wdata;
          SEL_RX_BLEN: rx_blen <= wdata;
          SEL_RX_BPR:  rx_bpr  <= wdata;
          SEL_RX_RUN: begin
            rx_run   <= wdata[0];
            rx_start <= wdata[0] & ~rx_run;
            rx_stop  <= ~wdata[0] & rx_run;
          end
          SEL_TX_DHI:  tx_dhi  <= wdata;
          SEL_TX_DLO: begin
            tx_dlo   <= wdata;
            tx_start <= 1'b1;
          end
          SEL_TX_BLEN: tx_blen <= wdata;
          SEL_TX_LEN:  tx_len  <= wdata;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (hit) begin
      case (sel)
        SEL_RX_DHI:  rdata = rx_dhi;
        SEL_RX_DLO:  rdata = rx_dlo;
        SEL_RX_LEN:  rdata = rx_len;
        SEL_RX_BLEN: rdata = rx_blen;
        SEL_RX_BPR:  rdata = rx_bpr;
        SEL_RX_RUN:  rdata = {31'b0, rx_run};
        SEL_TX_DHI:  rdata = tx_dhi;
        SEL_TX_DLO:  rdata = tx_dlo;
        SEL_TX_BLEN: rdata = tx_blen;
        SEL_TX_LEN:  rdata = tx_len;
        default:     rdata = '0;
      endcase
    end
  end

  assign rx_desc = {rx_dhi, rx_dlo};
  assign tx_desc = {tx_dhi, tx_dlo};
endmodule

// File: rtl/mdma_irq.sv
module mdma_irq
  import mdma_pkg::*;
#(
  parameter int NCH = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           st_wr,
  input  logic           en_wr,
  input  logic [31:0]    wdata,
  input  logic [NCH-1:0] done,
  output logic [NCH-1:0] status,
  output logic [NCH-1:0] enable,
  output logic [NCH-1:0] pending,
  output logic           irq
);
  logic [31:0] clr_mask, st_nxt, pend_full;

  always_comb begin
    clr_mask  = st_wr ? wdata : 32'b0;
    st_nxt    = stat_next(32'(status), clr_mask, 32'(done));
    pend_full = pend_of(32'(status), 32'(enable));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status <= '0;
      enable <= '0;
    end else begin
      status <= st_nxt[NCH-1:0];
      if (en_wr) enable <= wdata[NCH-1:0];
    end
  end

  assign pending = pend_full[NCH-1:0];
  assign irq     = |pending;
endmodule

// File: rtl/mdma_csr.sv
module mdma_csr
  import mdma_pkg::*;
#(
  parameter int NUM_PAIRS = 2,
  parameter int ADDR_W    = 20,
  localparam int NCH      = 2 * NUM_PAIRS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  input  logic              bus_we,
  output logic [31:0]       bus_rdata,
  input  logic [NCH-1:0]    done,
  output logic [NCH-1:0]    ch_start,
  output logic [NUM_PAIRS-1:0] rx_run,
  output logic [NUM_PAIRS-1:0] rx_stop,
  output logic [NCH*64-1:0] ch_desc_addr,
  output logic              addr32_mode,
  output logic              irq
);
  localparam int PAIR_W = (NUM_PAIRS > 1) ? $clog2(NUM_PAIRS) : 1;

  reg_sel_e          reg_sel;
  logic [PAIR_W-1:0] reg_pair;
  logic [31:0]       pair_rd [NUM_PAIRS];
  logic [NCH-1:0]    irq_status, irq_enable, irq_pending;
  logic              st_wr, en_wr;

  mdma_decode #(.ADDR_W(ADDR_W), .NUM_PAIRS(NUM_PAIRS), .PAIR_W(PAIR_W)) u_dec (
    .addr(bus_addr), .sel(reg_sel), .pair(reg_pair)
  );

  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
    logic pair_hit;
    assign pair_hit = (reg_pair == PAIR_W'(p));
    mdma_pair u_pair (
      .clk(clk), .rst_n(rst_n), .hit(pair_hit), .we(bus_we), .sel(reg_sel),
      .wdata(bus_wdata), .rdata(pair_rd[p]),
      .rx_run(rx_run[p]), .rx_start(ch_start[2*p]), .rx_stop(rx_stop[p]),
      .tx_start(ch_start[2*p+1]),
      .rx_desc(ch_desc_addr[(2*p)*64 +: 64]),
      .tx_desc(ch_desc_addr[(2*p+1)*64 +: 64])
    );
  end

  assign st_wr = bus_we && (reg_sel == SEL_ISTAT);
  assign en_wr = bus_we && (reg_sel == SEL_IEN);

  mdma_irq #(.NCH(NCH)) u_irq (
    .clk(clk), .rst_n(rst_n), .st_wr(st_wr), .en_wr(en_wr), .wdata(bus_wdata),
    .done(done), .status(irq_status), .enable(irq_enable),
    .pending(irq_pending), .irq(irq)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              addr32_mode <= 1'b0;
    else if (bus_we && reg_sel == SEL_ACTL)  addr32_mode <= bus_wdata[0];
  end

  always_comb begin
    bus_rdata = '0;
    for (int p = 0; p < NUM_PAIRS; p++) bus_rdata = bus_rdata | pair_rd[p];
    case (reg_sel)
      SEL_ACTL:  bus_rdata = {31'b0, addr32_mode};
      SEL_ISTAT: bus_rdata = 32'(irq_status);
      SEL_IPEND: bus_rdata = 32'(irq_pending);
      SEL_IEN:   bus_rdata = 32'(irq_enable);
      default: ;
    endcase
  end
endmodule

// File: rtl/mdma_csr_chk.sv
module mdma_csr_chk
  import mdma_pkg::*;
#(
  parameter int NUM_PAIRS = 2,
  parameter int NCH       = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 bus_we,
  input logic [31:0]          bus_wdata,
  input logic [31:0]          bus_rdata,
  input reg_sel_e             sel,
  input logic [NCH-1:0]       done,
  input logic [NCH-1:0]       status,
  input logic [NCH-1:0]       enable,
  input logic                 irq,
  input logic [NCH-1:0]       ch_start,
  input logic [NUM_PAIRS-1:0] rx_run,
  input logic [NUM_PAIRS-1:0] rx_stop
);
  // R7
  done_sets_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done != '0) |=> ((status & $past(done)) == $past(done)));

  // R8
  w1c_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && sel == SEL_ISTAT) |=>
      ((status & $past(bus_wdata[NCH-1:0]) & ~$past(done)) == '0));

  // R9
  pending_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == SEL_IPEND) |-> (bus_rdata == 32'(status & enable)));

  // R10
  irq_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && sel == SEL_IEN && bus_wdata[NCH-1:0] == '0) |=> !irq);

  // R4
  start_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ch_start));

  // R4
  start_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_start != '0) |-> $past(bus_we));

  // R5
  stop_clears_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_stop != '0) |-> ((rx_stop & rx_run) == '0));

  // R11
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == SEL_NONE) |-> (bus_rdata == '0));
endmodule

bind mdma_csr mdma_csr_chk #(.NUM_PAIRS(NUM_PAIRS), .NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_wdata(bus_wdata),
  .bus_rdata(bus_rdata), .sel(reg_sel), .done(done), .status(irq_status),
  .enable(irq_enable), .irq(irq), .ch_start(ch_start), .rx_run(rx_run),
  .rx_stop(rx_stop)
);

// File: tb/tb_mdma_csr.sv
module tb_mdma_csr;
  localparam int NUM_PAIRS = 2;
  localparam int ADDR_W    = 20;
  localparam int NCH       = 2 * NUM_PAIRS;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [31:0]       bus_wdata = '0;
  logic              bus_we = 1'b0;
  logic [31:0]       bus_rdata;
  logic [NCH-1:0]    done = '0;
  logic [NCH-1:0]    ch_start;
  logic [NUM_PAIRS-1:0] rx_run, rx_stop;
  logic [NCH*64-1:0] ch_desc_addr;
  logic              addr32_mode, irq;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  mdma_csr #(.NUM_PAIRS(NUM_PAIRS), .ADDR_W(ADDR_W)) dut (.*);

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // returns at the falling edge after the write edge
  task automatic wr(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = ADDR_W'(a); bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [31:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = ADDR_W'(a);
    #1 d = bus_rdata;
  endtask

  task automatic pulse_done(input logic [NCH-1:0] m);
    @(negedge clk);
    done = m;
    @(negedge clk);
    done = '0;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    chk("R12 ch_start", 64'(ch_start), 0);
    chk("R12 rx_run", 64'(rx_run), 0);
    chk("R12 irq", 64'(irq), 0);
    chk("R12 addr32", 64'(addr32_mode), 0);
    chk("R12 desc ch3", ch_desc_addr[3*64 +: 64], 0);
    rd(32'h080000, d); chk("R12 status", 64'(d), 0);
    rd(32'h040, d);    chk("R12 rx hi", 64'(d), 0);
  endtask

  task automatic t_rx_regs;
    logic [31:0] d;
    wr(32'h00, 32'h1111_0001); wr(32'h04, 32'h2222_0004);
    wr(32'h0C, 32'h3333_000C); wr(32'h10, 32'h4444_0010);
    wr(32'h30, 32'h5555_0030); wr(32'h54, 32'hFFFF_FFFE);
    rd(32'h00, d); chk("R1 rx dhi", 64'(d), 64'h1111_0001);
    rd(32'h04, d); chk("R1 rx dlo", 64'(d), 64'h2222_0004);
    rd(32'h0C, d); chk("R1 rx len", 64'(d), 64'h3333_000C);
    rd(32'h10, d); chk("R1 rx blen", 64'(d), 64'h4444_0010);
    rd(32'h30, d); chk("R1 rx bpr", 64'(d), 64'h5555_0030);
    rd(32'h54, d); chk("R1 rx run bit0 only", 64'(d), 0);
    chk("R1 run write no start", 64'(ch_start), 0);
  endtask

  task automatic t_tx_regs;
    logic [31:0] d;
    wr(32'h58, 32'hA000_0058); wr(32'h64, 32'hA000_0064);
    wr(32'h6C, 32'hA000_006C);
    rd(32'h58, d); chk("R2 tx dhi", 64'(d), 64'hA000_0058);
    rd(32'h64, d); chk("R2 tx blen", 64'(d), 64'hA000_0064);
    rd(32'h6C, d); chk("R2 tx len", 64'(d), 64'hA000_006C);
    rd(32'h44, d); chk("R2 rx dlo untouched", 64'(d), 0);
  endtask

  task automatic t_tx_start;
    logic [31:0] d;
    wr(32'h5C, 32'hBEEF_0100);
    chk("R4 tx start pulse", 64'(ch_start), 64'b1000);
    @(negedge clk);
    chk("R4 tx start gone", 64'(ch_start), 0);
    rd(32'h5C, d); chk("R2 tx dlo", 64'(d), 64'hBEEF_0100);
    chk("R3 desc ch3", ch_desc_addr[3*64 +: 64], 64'hA000_0058_BEEF_0100);
    chk("R3 desc ch0", ch_desc_addr[0 +: 64], 64'h1111_0001_2222_0004);
    wr(32'h1C, 32'h0000_0200);
    chk("R4 pair0 tx start", 64'(ch_start), 64'b0010);
  endtask

  task automatic t_rx_run;
    logic [31:0] d;
    wr(32'h14, 32'h1);
    chk("R5 rx start", 64'(ch_start), 64'b0001);
    chk("R5 run set", 64'(rx_run), 64'b01);
    @(negedge clk);
    chk("R5 start gone", 64'(ch_start), 0);
    wr(32'h14, 32'h1);
    chk("R5 rewrite no pulse", 64'(ch_start), 0);
    rd(32'h14, d); chk("R5 run readback", 64'(d), 1);
    wr(32'h14, 32'h0);
    chk("R5 stop pulse", 64'(rx_stop), 64'b01);
    chk("R5 run cleared", 64'(rx_run), 0);
    @(negedge clk);
    chk("R5 stop gone", 64'(rx_stop), 0);
    wr(32'h54, 32'h1);
    chk("R5 pair1 start", 64'(ch_start), 64'b0100);
  endtask

  task automatic t_actl;
    logic [31:0] d;
    wr(32'h34, 32'hFFFF_FFFF);
    chk("R6 addr32 set", 64'(addr32_mode), 1);
    rd(32'h34, d); chk("R6 readback", 64'(d), 1);
    wr(32'h74, 32'h0);
    chk("R6 other window ignored", 64'(addr32_mode), 1);
    wr(32'h34, 32'h0);
    chk("R6 addr32 clear", 64'(addr32_mode), 0);
  endtask

  task automatic t_status;
    logic [31:0] d;
    pulse_done(4'b0110);
    rd(32'h080000, d); chk("R7 done sets status", 64'(d), 64'h6);
    wr(32'h080000, 32'h2);
    rd(32'h080000, d); chk("R8 w1c one bit", 64'(d), 64'h4);
    @(negedge clk);
    bus_addr = ADDR_W'(32'h080000); bus_wdata = 32'hF; bus_we = 1'b1; done = 4'b0001;
    @(negedge clk);
    bus_we = 1'b0; done = '0;
    rd(32'h080000, d); chk("R7 set wins over clear", 64'(d), 64'h1);
    wr(32'h080000, 32'hFFFF_FFFF);
    rd(32'h080000, d); chk("R8 clear all", 64'(d), 0);
  endtask

  task automatic t_irq;
    logic [31:0] d;
    wr(32'h080008, 32'h5);
    rd(32'h080008, d); chk("R9 enable readback", 64'(d), 64'h5);
    pulse_done(4'b0010);
    chk("R10 masked no irq", 64'(irq), 0);
    rd(32'h080004, d); chk("R9 pending masked", 64'(d), 0);
    pulse_done(4'b0100);
    chk("R10 irq high", 64'(irq), 1);
    rd(32'h080004, d); chk("R9 pending", 64'(d), 64'h4);
    wr(32'h080004, 32'hF);
    rd(32'h080000, d); chk("R9 pending write ignored", 64'(d), 64'h6);
    wr(32'h080008, 32'h0);
    chk("R10 irq off", 64'(irq), 0);
    rd(32'h080000, d); chk("R10 status kept", 64'(d), 64'h6);
    wr(32'h080000, 32'hFFFF_FFFF);
  endtask

  task automatic t_unmapped;
    logic [31:0] d;
    wr(32'h08, 32'hDEAD_BEEF);
    rd(32'h08, d); chk("R11 ofs 08 reads 0", 64'(d), 0);
    rd(32'h04, d); chk("R11 ofs 08 no effect", 64'(d), 64'h2222_0004);
    wr(32'h20, 32'hDEAD_BEEF);
    rd(32'h20, d); chk("R11 ofs 20 reads 0", 64'(d), 0);
    rd(32'h1C, d); chk("R11 ofs 20 no effect", 64'(d), 64'h0000_0200);
    wr(32'h80, 32'h1234_5678);
    rd(32'h80, d); chk("R11 window 2 reads 0", 64'(d), 0);
    rd(32'h00, d); chk("R11 window 2 no alias", 64'(d), 64'h1111_0001);
    rd(32'h08000C, d); chk("R11 global gap", 64'(d), 0);
    rd(32'h74, d); chk("R11 actl other window", 64'(d), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_rx_regs();
    t_tx_regs();
    t_tx_start();
    t_rx_run();
    t_actl();
    t_status();
    t_irq();
    t_unmapped();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL R12 watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule